// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block holds the event status, interrupt enable and wakeup enable registers of an I2C controller. The bus engine and the FIFO logic report events to it as one-cycle pulses. The block latches each pulse into a sticky status flag, and the flag stays set until software clears it. The two data-ready flags differ: they follow live FIFO threshold levels, so they come back after a clear for as long as the threshold condition still holds. Bus busy is not stored. It is a live copy of an input that shows up in the status word.

A single level interrupt request is raised while any pending flag is also enabled. A separate wakeup mask reuses the status bit positions and drives a wakeup request. In that mask, one bit covers both data-ready flags, and three bits respond to bus events that have no status flag: general call, start condition and bus becoming free. Software reaches all three registers through a small register port with a combinational read path.

Top module: `i2c_irq_status`

## Requirements
- R1: Reset clears the status, enable and wakeup registers. While reset is held, `irqReq` and `wakeReq` are low.
- R2: A one-cycle pulse on `evPulse` at a storable position sets that status flag at the next clock edge, and the flag then stays set. The storable positions are: 0 arbitration lost, 1 no-ack, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain. Pulses at any other position have no effect.
- R3: Register addresses are 0 for status, 1 for enable and 2 for wakeup mask. A write to status clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R4: If an event pulse and a write-1 clear reach the same flag in the same cycle, the flag is set after the edge.
- R5: `irqReq` is high exactly while (status AND enable) is nonzero. It falls only once every enabled pending flag has been cleared.
- R6: Only enable bits 0–4, 13 and 14 can be written, and the other bits read 0. Writing 0 to enable drops `irqReq` but leaves the status flags pending.
- R7: Status bit 12 reads the live `busBusy` input. Writing 1 to it has no effect, and it never raises `irqReq`.
- R8: While `rxReady` or `txReady` is high, it sets status bit 3 or bit 4 respectively at each edge. A write-1 clear of such a flag takes effect for one cycle, and the flag is set again at the following edge if its level is still high.
- R9: Wakeup mask bits 0, 1, 2, 3, 5, 6, 8, 9, 13 and 14 can be written, and the others read 0. `wakeReq` is high while status bits 0, 1, 2, 9, 13 or 14 are set together with the same mask bit.
- R10: Wakeup mask bit 3 wakes on either data-ready flag (status bit 3 or 4). Mask bits 5, 6 and 8 raise `wakeReq` for the one cycle after a `genCallPulse`, a `startPulse`, or a falling edge of `busBusy` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register select: 0 status, 1 enable, 2 wakeup mask |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data of the selected register |
| evPulse | input | 16 | Event pulses at status bit positions |
| rxReady | input | 1 | Receive FIFO threshold level |
| txReady | input | 1 | Transmit FIFO threshold level |
| busBusy | input | 1 | Live bus busy level |
| genCallPulse | input | 1 | General call detected pulse |
| startPulse | input | 1 | Start condition detected pulse |
| irqReq | output | 1 | Level interrupt request |
| wakeReq | output | 1 | Wakeup request |

## Verification
The hardest situation to reach is an event pulse and a software clear hitting the same flag in the same cycle, together with a clear of a data-ready flag whose FIFO level is still high. Only in that second case does the flag go low for exactly one cycle. Directed writes are therefore timed on the same edge as a driven pulse or level. A long phase of sparse random pulses, levels and register writes then produces further collisions, and a behavioural reference model checks the interrupt, wakeup and read data on every cycle.

// File: rtl/i2c_irq_status_pkg.sv
package i2c_irq_status_pkg;
  localparam int REG_W = 16;

  localparam int ADR_STATUS = 0;
  localparam int ADR_ENABLE = 1;
  localparam int ADR_WAKE   = 2;

  localparam int RX_BIT   = 3;
  localparam int TX_BIT   = 4;
  localparam int BUSY_BIT = 12;
  localparam int DR_WAKE_BIT = 3;
  localparam int GC_WAKE_BIT = 5;
  localparam int ST_WAKE_BIT = 6;
  localparam int BF_WAKE_BIT = 8;

  localparam logic [REG_W-1:0] STORE_MASK     = 16'h6F1F;
  localparam logic [REG_W-1:0] EN_MASK        = 16'h601F;
  localparam logic [REG_W-1:0] WAKE_MASK      = 16'h636F;
  localparam logic [REG_W-1:0] WAKE_STAT_MASK = 16'h6207;

  typedef struct packed {
    logic             wrStatus;
    logic             wrEnable;
    logic             wrWake;
    logic [REG_W-1:0] data;
  } ctrlStrobes_t;
endpackage

// File: rtl/i2c_irq_status_ctrl.sv
module i2c_irq_status_ctrl
  import i2c_irq_status_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [REG_W-1:0]  statusQ,
  input  logic [REG_W-1:0]  enableQ,
  input  logic [REG_W-1:0]  wakeQ,
  input  logic              busBusy,
  output ctrlStrobes_t      strb,
  output logic [REG_W-1:0]  regRdData
);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(ADR_ENABLE);
  localparam logic [ADDR_W-1:0] A_WK = ADDR_W'(ADR_WAKE);

  logic selSt, selEn, selWk;
  assign selSt = (regAddr == A_ST);
  assign selEn = (regAddr == A_EN);
  assign selWk = (regAddr == A_WK);

  always_comb begin
    strb.wrStatus = regWrEn & selSt;
    strb.wrEnable = regWrEn & selEn;
    strb.wrWake   = regWrEn & selWk;
    strb.data     = regWrData;
  end

  logic [REG_W-1:0] busyWord;
  assign busyWord = {{(REG_W-1){1'b0}}, busBusy} << BUSY_BIT;

  always_comb begin
    regRdData = '0;
    if (selSt)      regRdData = statusQ | busyWord;
    else if (selEn) regRdData = enableQ;
    else if (selWk) regRdData = wakeQ;
  end
endmodule

// File: rtl/i2c_irq_status_dp.sv
module i2c_irq_status_dp
  import i2c_irq_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [REG_W-1:0] evPulse,
  input  logic             rxReady,
  input  logic             txReady,
  input  logic             busBusy,
  input  logic             genCallPulse,
  input  logic             startPulse,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] enableQ,
  output logic [REG_W-1:0] wakeQ,
  output logic             irqReq,
  output logic             wakeReq
);
  logic [REG_W-1:0] stNext;
  logic unusedEv;
  assign unusedEv = ^(evPulse & ~STORE_MASK);

  for (genvar i = 0; i < REG_W; i++) begin : gStat
    if (STORE_MASK[i]) begin : gKeep
      logic clrHit, setHit;
      assign clrHit = strb.wrStatus & strb.data[i];
      if (i == RX_BIT || i == TX_BIT) begin : gLevel
        logic lvl;
        assign lvl    = (i == RX_BIT) ? rxReady : txReady;
        assign setHit = evPulse[i] | (lvl & ~clrHit);
      end else begin : gPulse
        assign setHit = evPulse[i];
      end
      assign stNext[i] = setHit | (statusQ[i] & ~clrHit);
    end else begin : gZero
      assign stNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= stNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enableQ <= '0;
    else if (strb.wrEnable) enableQ <= strb.data & EN_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wakeQ <= '0;
    else if (strb.wrWake) wakeQ <= strb.data & WAKE_MASK;
  end

  logic busPrev;
  logic [2:0] wkEvQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPrev <= 1'b0;
      wkEvQ   <= '0;
    end else begin
      busPrev <= busBusy;
      wkEvQ   <= {busPrev & ~busBusy, startPulse, genCallPulse};
    end
  end

  logic statWake, drWake, evWake;
  assign statWake = |(statusQ & wakeQ & WAKE_STAT_MASK);
  assign drWake   = wakeQ[DR_WAKE_BIT] & (statusQ[RX_BIT] | statusQ[TX_BIT]);
  assign evWake   = (wakeQ[GC_WAKE_BIT] & wkEvQ[0]) |
                    (wakeQ[ST_WAKE_BIT] & wkEvQ[1]) |
                    (wakeQ[BF_WAKE_BIT] & wkEvQ[2]);

  assign irqReq  = |(statusQ & enableQ);
  assign wakeReq = statWake | drWake | evWake;
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_status_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic [15:0]       evPulse,
  input  logic              rxReady,
  input  logic              txReady,
  input  logic              busBusy,
  input  logic              genCallPulse,
  input  logic              startPulse,
  output logic              irqReq,
  output logic              wakeReq
);
  ctrlStrobes_t     strb;
  logic [REG_W-1:0] statusQ, enableQ, wakeQ;

  i2c_irq_status_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .statusQ(statusQ), .enableQ(enableQ), .wakeQ(wakeQ),
    .busBusy(busBusy), .strb(strb), .regRdData(regRdData)
  );

  i2c_irq_status_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .evPulse(evPulse),
    .rxReady(rxReady), .txReady(txReady), .busBusy(busBusy),
    .genCallPulse(genCallPulse), .startPulse(startPulse),
    .statusQ(statusQ), .enableQ(enableQ), .wakeQ(wakeQ),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [15:0]       regWrData,
  input logic [15:0]       regRdData,
  input logic [15:0]       evPulse,
  input logic              rxReady,
  input logic              busBusy,
  input logic              irqReq,
  input logic [15:0]       statusQ
);
  logic wrSt, wrEn;
  assign wrSt = regWrEn && (regAddr == ADDR_W'(0));
  assign wrEn = regWrEn && (regAddr == ADDR_W'(1));

  a_r3_clear_bit0: assert property (@(posedge clk) disable iff (!rstN)
    (wrSt && regWrData[0] && !evPulse[0]) |=> !statusQ[0]);

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrSt && regWrData[1] && evPulse[1]) |=> statusQ[1]);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[9] && !(wrSt && regWrData[9])) |=> statusQ[9]);

  a_r6_mask_all: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regWrData == 16'h0000) |=> !irqReq);

  a_r7_busy_live: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> (regRdData[12] == busBusy));

  a_r8_level_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !(wrSt && regWrData[3])) |=> statusQ[3]);
endmodule

bind i2c_irq_status i2c_irq_status_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .evPulse(evPulse),
  .rxReady(rxReady), .busBusy(busBusy), .irqReq(irqReq),
  .statusQ(statusQ)
);

// File: tb/i2c_irq_status_test.sv
module i2c_irq_status_test;
  localparam int AW = 3;
  logic clk = 0, rstN = 0;
  logic [AW-1:0] regAddr = 0;
  logic regWrEn = 0;
  logic [15:0] regWrData = 0, regRdData, evPulse = 0;
  logic rxReady = 0, txReady = 0, busBusy = 0, genCallPulse = 0, startPulse = 0;
  logic irqReq, wakeReq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  i2c_irq_status #(.ADDR_W(AW)) uut (.*);

  // behavioural reference model
  int mSt = 0, mEn = 0, mWk = 0, mEv = 0, mPrevBusy = 0;
  always @(posedge clk) begin
    int clr, lvl;
    if (!rstN) begin
      mSt = 0; mEn = 0; mWk = 0; mEv = 0; mPrevBusy = 0;
    end else begin
      clr = (regWrEn && regAddr == 0) ? (regWrData & 'h6F1F) : 0;
      lvl = (rxReady ? 'h8 : 0) | (txReady ? 'h10 : 0);
      mSt = (mSt & ~clr) | (evPulse & 'h6F1F) | (lvl & ~clr);
      if (regWrEn && regAddr == 1) mEn = regWrData & 'h601F;
      if (regWrEn && regAddr == 2) mWk = regWrData & 'h636F;
      mEv = (genCallPulse ? 1 : 0) | (startPulse ? 2 : 0) | ((mPrevBusy && !busBusy) ? 4 : 0);
      mPrevBusy = busBusy ? 1 : 0;
    end
  end

  function automatic int expRd(int a);
    if (a == 0) return mSt | (busBusy ? 'h1000 : 0);
    if (a == 1) return mEn;
    if (a == 2) return mWk;
    return 0;
  endfunction
  function automatic bit expWake();
    bit w;
    w = (mSt & mWk & 'h6207) != 0;
    if ((mWk & 'h8) && (mSt & 'h18)) w = 1;
    if ((mWk & 'h20) && (mEv & 1)) w = 1;
    if ((mWk & 'h40) && (mEv & 2)) w = 1;
    if ((mWk & 'h100) && (mEv & 4)) w = 1;
    return w;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(irqReq == ((mSt & mEn) != 0), "R5 irq", irqReq, (mSt & mEn) != 0);
    chk(wakeReq == expWake(), "R9/R10 wake", wakeReq, expWake());
    chk(int'(regRdData) == expRd(int'(regAddr)), "R3 read", regRdData, expRd(int'(regAddr)));
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compareAll();
    evPulse = 0; genCallPulse = 0; startPulse = 0; regWrEn = 0;
  endtask

  task automatic wr(int a, int d);
    regAddr = AW'(a); regWrData = 16'(d); regWrEn = 1;
    tick();
  endtask

  task automatic rdChk(int a, int exp, string req);
    regAddr = AW'(a); #1;
    chk(int'(regRdData) == exp, req, regRdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!irqReq && !wakeReq, "R1 outputs in reset", {irqReq, wakeReq}, 0);
    rstN = 1; @(negedge clk);
    rdChk(0, 0, "R1 status"); rdChk(1, 0, "R1 enable"); rdChk(2, 0, "R1 wake");

    // R2 sticky events, incl. an unstorable position (bit 5)
    evPulse = 16'h0A21; tick();
    repeat (4) tick();
    rdChk(0, 'h0A01, "R2 sticky flags");
    // R5 irq
    wr(1, 'h0001);
    chk(irqReq == 1, "R5 irq set", irqReq, 1);
    // R3 W1C multiple, zero write
    wr(0, 'h0A00); rdChk(0, 'h0001, "R3 clear two");
    wr(0, 'h0000); rdChk(0, 'h0001, "R3 zero write");
    // R6 mask all keeps pending
    wr(1, 'h0000);
    chk(irqReq == 0, "R6 masked", irqReq, 0);
    rdChk(0, 'h0001, "R6 still pending");
    wr(1, 'hFFFF); rdChk(1, 'h601F, "R6 enable bits");
    wr(0, 'h0001);
    chk(irqReq == 0, "R5 cleared", irqReq, 1'b0);
    // R4 set beats clear
    evPulse = 'h0002; wr(0, 'h0002);
    rdChk(0, 'h0002, "R4 set wins");
    wr(0, 'h0002);
    // R7 busy live
    busBusy = 1; tick();
    rdChk(0, 'h1000, "R7 busy visible");
    wr(0, 'h1000); rdChk(0, 'h1000, "R7 busy not cleared");
    chk(irqReq == 0, "R7 busy no irq", irqReq, 0);
    // R8 level re-set
    rxReady = 1; tick();
    rdChk(0, 'h1008, "R8 level sets");
    wr(0, 'h0008); rdChk(0, 'h1000, "R8 one-cycle drop");
    tick(); rdChk(0, 'h1008, "R8 re-set");
    rxReady = 0; wr(0, 'h0008); tick(); rdChk(0, 'h1000, "R8 stays clear");
    // R9 wake mask layout
    wr(2, 'hFFFF); rdChk(2, 'h636F, "R9 wake bits");
    wr(2, 'h0200); evPulse = 'h0200; tick();
    chk(wakeReq == 1, "R9 status wake", wakeReq, 1);
    wr(0, 'h0200);
    // R10 data-ready shared bit
    wr(2, 'h0008); txReady = 1; tick();
    chk(wakeReq == 1, "R10 tx wake via bit3", wakeReq, 1);
    txReady = 0; wr(0, 'h0010);
    chk(wakeReq == 0, "R10 wake drops", wakeReq, 0);
    wr(2, 'h0160); genCallPulse = 1; tick();
    chk(wakeReq == 1, "R10 general call", wakeReq, 1);
    tick(); chk(wakeReq == 0, "R10 one cycle", wakeReq, 0);
    startPulse = 1; tick();
    chk(wakeReq == 1, "R10 start", wakeReq, 1);
    busBusy = 0; tick();
    chk(wakeReq == 1, "R10 bus free", wakeReq, 1);

    // random phase, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      evPulse = (r[3:0] == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      rxReady = (r[7:4] < 3); txReady = (r[11:8] < 3);
      if (r[15:12] == 0) busBusy = ~busBusy;
      genCallPulse = (r[19:16] == 0); startPulse = (r[23:20] == 0);
      regAddr = AW'($urandom_range(0, 3));
      regWrEn = (r[27:24] < 3);
      regWrData = 16'($urandom);
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule